// File: doc/BRIEF.md
# DMA Global Enable and Stop Controller

This block is the shared control point of a six-channel DMA engine. It holds one master-enable bit and two sticky stop flags: one for a non-maskable interrupt and one for an address error. Each channel reports its own enable, its end-of-transfer flag, whether a transfer unit is in flight, and a one-cycle pulse when that unit ends. From these inputs the block produces one registered grant per channel. When the master enable goes low or a stop flag is set, a channel that is in the middle of a unit keeps its grant until the unit ends. A channel that is idle loses its grant at once.

The block also routes peripheral requests. Three 16-bit selector registers each cover a pair of channels. The low byte names the peripheral request line for the even channel and the high byte names it for the odd channel. A channel takes that routed request only while its 4-bit resource-select input is in extended mode (4'b1000). A small register port with a single-cycle read and write handles the control word and the selector registers. The stop flags clear only through a read-then-write-zero sequence.

Top module: `dma_gate_ctrl`

## Requirements
- R1: After reset, every grant, every source select, every extended request and the read data are 0. The control word (address 0) reads 0: bit 0 is the master enable, bit 1 the NMI flag, bit 2 the address-error flag.
- R2: A channel's grant is 1 one cycle after all of these hold together: master enable is 1, channel enable is 1, its end flag is 0, and both stop flags are 0. When any of these fails and the channel is not busy, the grant falls one cycle later.
- R3: A pulse on `nmi_in` sets the NMI flag on the next edge. This happens even when master enable is 0 and no channel is active. The flag reads back as bit 1 of address 0.
- R4: While the NMI flag is 1, no grant rises. A busy channel keeps its grant until the edge where its `unit_done` is 1. An idle channel drops its grant one cycle after the flag is set.
- R5: A stop flag is cleared by a write to address 0 with that bit at 0, but only if the last access to address 0 before it was a read that returned the flag as 1. Writing 1 to the flag bit never clears it. Any write to address 0 cancels an earlier qualifying read.
- R6: If an NMI pulse comes in the same cycle as a qualifying clearing write, the NMI flag stays 1.
- R7: Writing master enable to 0 stops all channels in the same graceful way as R4: busy channels keep their grant until `unit_done`.
- R8: A pulse on `addr_err_in` sets the address-error flag (bit 2). That flag blocks grants like the NMI flag and clears by the same rule as R5.
- R9: Addresses 1, 2 and 3 are 16-bit selector registers for channel pairs 0–1, 2–3 and 4–5. The low byte belongs to the even channel and the high byte to the odd channel. Each register reads back the value written.
- R10: While a channel's resource-select field equals 4'b1000, its registered source select equals its selector byte, and its extended request follows `periph_req[selector]` one cycle later. For any other resource-select value, both outputs are 0 whatever the selector and the request lines hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after `reg_rd` |
| nmi_in | input | 1 | Non-maskable interrupt pulse |
| addr_err_in | input | 1 | Address-error pulse |
| ch_en | input | 6 | Per-channel enable |
| ch_end | input | 6 | Per-channel transfer-end flag |
| ch_busy | input | 6 | Per-channel unit in flight |
| unit_done | input | 6 | Per-channel one-cycle end-of-unit pulse |
| ch_rs | input | 24 | Per-channel 4-bit resource-select field, channel n at bits 4n+3:4n |
| periph_req | input | 16 | Peripheral request lines |
| ch_grant | output | 6 | Per-channel transfer grant |
| ch_src_sel | output | 48 | Per-channel selected source, channel n at bits 8n+7:8n |
| ch_ext_req | output | 6 | Per-channel accepted extended request |

## Verification
The hardest situations to reach are the clearing races. The flag must be cleared by a write that depends on an earlier read, and that write must also meet an NMI pulse in the same cycle. The bench first reads the flag as 1 to arm the clear, then drives the clearing write and `nmi_in` in one cycle. A second path inserts a write of 1 between the read and the write of 0 to show that the arming is cancelled. The graceful stop is reached by holding one channel busy while the others are idle. The bench then checks that the grants split for one cycle before `unit_done` closes the busy channel.

// File: rtl/dgc_pkg.sv
package dgc_pkg;
  localparam int REG_W   = 16;
  localparam int SEL_W   = 8;
  localparam int RS_W    = 4;
  localparam logic [RS_W-1:0] RS_EXT = 4'b1000;
  localparam int DME_BIT = 0;
  localparam int NMI_BIT = 1;
  localparam int AE_BIT  = 2;

  typedef struct packed {
    logic aef;
    logic nmif;
    logic dme;
  } gstat_t;
endpackage

// File: rtl/dgc_flag.sv
module dgc_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q;
  logic armed_q;
  logic clr;

  assign clr = wr_i && armed_q && !wbit_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (set_i)    flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
      if (wr_i)                 armed_q <= 1'b0;
      else if (rd_i && flag_q)  armed_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  assert_flag_sets_R3: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);

  assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (set_i && wr_i && !wbit_i) |=> flag_o);

  assert_clear_needs_read_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(flag_o)) |-> ($past(armed_q) && $past(wr_i) && !$past(wbit_i)));

  assert_one_write_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !set_i) |=> !armed_q);
endmodule

// File: rtl/dgc_regs.sv
module dgc_regs
  import dgc_pkg::*;
#(
  parameter int NPAIR  = 3,
  parameter int ADDR_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_wr,
  input  logic                    reg_rd,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [REG_W-1:0]        reg_wdata,
  output logic [REG_W-1:0]        reg_rdata,
  input  logic                    nmi_in,
  input  logic                    addr_err_in,
  output gstat_t                  gstat,
  output logic [NPAIR*REG_W-1:0]  sel_flat
);
  logic             ctrl_hit;
  logic             ctrl_wr;
  logic             ctrl_rd;
  logic             dme_q;
  logic             nmif;
  logic             aef;
  logic [REG_W-1:0] sel_q [NPAIR];
  logic [REG_W-1:0] rd_mux;

  assign ctrl_hit = (reg_addr == '0);
  assign ctrl_wr  = reg_wr && ctrl_hit;
  assign ctrl_rd  = reg_rd && ctrl_hit;

  always_ff @(posedge clk) begin
    if (rst)          dme_q <= 1'b0;
    else if (ctrl_wr) dme_q <= reg_wdata[DME_BIT];
  end

  dgc_flag nmi_flag_i (
    .clk(clk), .rst(rst), .set_i(nmi_in), .rd_i(ctrl_rd),
    .wr_i(ctrl_wr), .wbit_i(reg_wdata[NMI_BIT]), .flag_o(nmif)
  );

  dgc_flag ae_flag_i (
    .clk(clk), .rst(rst), .set_i(addr_err_in), .rd_i(ctrl_rd),
    .wr_i(ctrl_wr), .wbit_i(reg_wdata[AE_BIT]), .flag_o(aef)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst)
        sel_q[p] <= '0;
      else if (reg_wr && reg_addr == ADDR_W'(p + 1))
        sel_q[p] <= reg_wdata;
    end
    assign sel_flat[p*REG_W +: REG_W] = sel_q[p];
  end

  always_comb begin
    rd_mux = '0;
    if (ctrl_hit) begin
      rd_mux[DME_BIT] = dme_q;
      rd_mux[NMI_BIT] = nmif;
      rd_mux[AE_BIT]  = aef;
    end
    for (int p = 0; p < NPAIR; p++)
      if (reg_addr == ADDR_W'(p + 1)) rd_mux = sel_q[p];
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
    else             reg_rdata <= '0;
  end

  assign gstat.dme  = dme_q;
  assign gstat.nmif = nmif;
  assign gstat.aef  = aef;

  assert_dme_follows_write_R2: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (gstat.dme == $past(reg_wdata[DME_BIT])));

  assert_ae_sets_R8: assert property (@(posedge clk) disable iff (rst)
    addr_err_in |=> gstat.aef);
endmodule

// File: rtl/dgc_chan.sv
module dgc_chan
  import dgc_pkg::*;
#(
  parameter int NREQ = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             glob_ok,
  input  logic             en,
  input  logic             te,
  input  logic             busy,
  input  logic             done,
  input  logic [RS_W-1:0]  rs,
  input  logic [SEL_W-1:0] selector,
  input  logic [NREQ-1:0]  periph_req,
  output logic             grant,
  output logic [SEL_W-1:0] src_sel,
  output logic             ext_req
);
  logic permit;
  logic ext_mode;
  logic req_hit;

  assign permit   = glob_ok && en && !te;
  assign ext_mode = (rs == RS_EXT);

  always_comb begin
    req_hit = 1'b0;
    for (int i = 0; i < NREQ; i++)
      if (selector == SEL_W'(i)) req_hit = periph_req[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant   <= 1'b0;
      src_sel <= '0;
      ext_req <= 1'b0;
    end else begin
      if (permit)            grant <= 1'b1;
      else if (done || !busy) grant <= 1'b0;
      src_sel <= ext_mode ? selector : '0;
      ext_req <= ext_mode && req_hit;
    end
  end

  assert_grant_needs_permit_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(grant) |-> $past(glob_ok && en && !te));

  assert_busy_keeps_grant_R4: assert property (@(posedge clk) disable iff (rst)
    (grant && busy && !done) |=> grant);

  assert_ext_only_in_mode_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ext_req) |-> ($past(rs) == RS_EXT));

  assert_sel_zero_outside_R10: assert property (@(posedge clk) disable iff (rst)
    !ext_mode |=> (src_sel == '0));
endmodule

// File: rtl/dma_gate_ctrl.sv
module dma_gate_ctrl
  import dgc_pkg::*;
#(
  parameter int NCH  = 6,
  parameter int NREQ = 16,
  localparam int NPAIR  = NCH / 2,
  localparam int ADDR_W = $clog2(NPAIR + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  input  logic                  nmi_in,
  input  logic                  addr_err_in,
  input  logic [NCH-1:0]        ch_en,
  input  logic [NCH-1:0]        ch_end,
  input  logic [NCH-1:0]        ch_busy,
  input  logic [NCH-1:0]        unit_done,
  input  logic [NCH*RS_W-1:0]   ch_rs,
  input  logic [NREQ-1:0]       periph_req,
  output logic [NCH-1:0]        ch_grant,
  output logic [NCH*SEL_W-1:0]  ch_src_sel,
  output logic [NCH-1:0]        ch_ext_req
);
  gstat_t                   gstat;
  logic [NPAIR*REG_W-1:0]   sel_flat;
  logic                     glob_ok;

  dgc_regs #(.NPAIR(NPAIR), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .nmi_in(nmi_in), .addr_err_in(addr_err_in),
    .gstat(gstat), .sel_flat(sel_flat)
  );

  assign glob_ok = gstat.dme && !gstat.nmif && !gstat.aef;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dgc_chan #(.NREQ(NREQ)) chan_i (
      .clk(clk), .rst(rst), .glob_ok(glob_ok),
      .en(ch_en[c]), .te(ch_end[c]), .busy(ch_busy[c]), .done(unit_done[c]),
      .rs(ch_rs[c*RS_W +: RS_W]),
      .selector(sel_flat[c*SEL_W +: SEL_W]),
      .periph_req(periph_req),
      .grant(ch_grant[c]),
      .src_sel(ch_src_sel[c*SEL_W +: SEL_W]),
      .ext_req(ch_ext_req[c])
    );
  end

  assert_stop_blocks_rise_R4: assert property (@(posedge clk) disable iff (rst)
    (gstat.nmif || gstat.aef || !gstat.dme) |=> ((ch_grant & ~$past(ch_grant)) == '0));
endmodule

// File: tb/dma_gate_ctrl_tb_top.sv
module dma_gate_ctrl_tb_top;
  localparam int NCH = 6;
  localparam int NREQ = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic nmi_in = 1'b0, addr_err_in = 1'b0;
  logic [NCH-1:0] ch_en = '0, ch_end = '0, ch_busy = '0, unit_done = '0;
  logic [NCH*4-1:0] ch_rs = '0;
  logic [NREQ-1:0] periph_req = '0;
  logic [NCH-1:0] ch_grant;
  logic [NCH*8-1:0] ch_src_sel;
  logic [NCH-1:0] ch_ext_req;

  int checks = 0;
  int failures = 0;
  logic [15:0] rv;

  always #2ns clk = ~clk;

  dma_gate_ctrl #(.NCH(NCH), .NREQ(NREQ)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_in(nmi_in),
    .addr_err_in(addr_err_in), .ch_en(ch_en), .ch_end(ch_end), .ch_busy(ch_busy),
    .unit_done(unit_done), .ch_rs(ch_rs), .periph_req(periph_req),
    .ch_grant(ch_grant), .ch_src_sel(ch_src_sel), .ch_ext_req(ch_ext_req)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse_nmi();
    nmi_in = 1'b1; @(negedge clk); nmi_in = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 grant", ch_grant, 0);
    check("R1 src_sel", ch_src_sel, 0);
    check("R1 ext_req", ch_ext_req, 0);
    check("R1 rdata idle", reg_rdata, 0);
    rd(0, rv); check("R1 ctrl", rv, 0);
  endtask

  task automatic t_nmi_idle();
    pulse_nmi();
    rd(0, rv); check("R3 idle nmi flag", rv, 16'h0002);
    wr(0, 16'h0000);
    rd(0, rv); check("R5 cleared after read", rv, 0);
  endtask

  task automatic t_permit();
    ch_en = '1; ch_end = '0; ch_busy = '0;
    @(negedge clk);
    check("R2 no grant without master", ch_grant, 0);
    wr(0, 16'h0001);
    @(negedge clk);
    check("R2 all granted", ch_grant, 6'h3F);
    ch_end[2] = 1'b1;
    @(negedge clk);
    check("R2 end flag drops ch2", ch_grant, 6'h3B);
  endtask

  task automatic t_nmi_stop();
    ch_busy = 6'h01;
    pulse_nmi();
    @(negedge clk);
    check("R4 idle channels stop", ch_grant, 6'h01);
    @(negedge clk);
    check("R4 busy channel holds", ch_grant, 6'h01);
    unit_done[0] = 1'b1; @(negedge clk); unit_done[0] = 1'b0;
    check("R4 stop at unit end", ch_grant, 0);
    ch_busy = '0;
  endtask

  task automatic t_clear_rule();
    rd(0, rv); check("R3 flag reads 1", rv, 16'h0003);
    wr(0, 16'h0003);
    wr(0, 16'h0001);
    rd(0, rv); check("R5 disarmed write no clear", rv, 16'h0003);
    check("R4 no grant while flag", ch_grant, 0);
    wr(0, 16'h0001);
    rd(0, rv); check("R5 armed clear", rv, 16'h0001);
    check("R2 grants resume", ch_grant, 6'h3B);
  endtask

  task automatic t_nmi_race();
    pulse_nmi();
    rd(0, rv);
    reg_wr = 1'b1; reg_addr = 0; reg_wdata = 16'h0001; nmi_in = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; nmi_in = 1'b0;
    rd(0, rv); check("R6 nmi beats clear", rv, 16'h0003);
    wr(0, 16'h0001);
    rd(0, rv); check("R6 later clear works", rv, 16'h0001);
  endtask

  task automatic t_addr_err();
    @(negedge clk);
    check("R8 pre grants", ch_grant, 6'h3B);
    addr_err_in = 1'b1; @(negedge clk); addr_err_in = 1'b0;
    @(negedge clk);
    check("R8 ae stops grants", ch_grant, 0);
    rd(0, rv); check("R8 ae flag bit2", rv, 16'h0005);
    wr(0, 16'h0001);
    rd(0, rv); check("R8 ae cleared", rv, 16'h0001);
    check("R8 grants resume", ch_grant, 6'h3B);
  endtask

  task automatic t_dme_off();
    ch_busy = 6'h02;
    wr(0, 16'h0000);
    @(negedge clk);
    check("R7 idle stop busy hold", ch_grant, 6'h02);
    unit_done[1] = 1'b1; @(negedge clk); unit_done[1] = 1'b0;
    check("R7 busy stops at unit end", ch_grant, 0);
    ch_busy = '0;
  endtask

  task automatic t_select();
    wr(1, 16'h0503);
    wr(3, 16'h0A07);
    wr(2, 16'h0C0B);
    rd(1, rv); check("R9 pair0 readback", rv, 16'h0503);
    rd(2, rv); check("R9 pair1 readback", rv, 16'h0C0B);
    rd(3, rv); check("R9 pair2 readback", rv, 16'h0A07);
    ch_rs = {4'h8, 4'h8, 4'h0, 4'h0, 4'h7, 4'h8};
    periph_req = 16'h00A8;
    @(negedge clk);
    check("R10 ext req mode gated", ch_ext_req, 6'b010001);
    check("R10 src sel ch0", ch_src_sel[7:0], 8'h03);
    check("R10 src sel ch1 ignored", ch_src_sel[15:8], 8'h00);
    check("R9 src sel ch5 high byte", ch_src_sel[47:40], 8'h0A);
    ch_rs[7:4] = 4'h8;
    @(negedge clk);
    check("R10 ch1 now accepted", ch_ext_req, 6'b010011);
    check("R9 src sel ch1 high byte", ch_src_sel[15:8], 8'h05);
    periph_req = '0;
    @(negedge clk);
    check("R10 req follows line", ch_ext_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_nmi_idle();
    t_permit();
    t_nmi_stop();
    t_clear_rule();
    t_nmi_race();
    t_addr_err();
    t_dme_off();
    t_select();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4ns * 20000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule